// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital front end of a single 12-bit converter whose input is picked by a multiplexer. Software reaches it over a small 8-bit register bus. That bus exposes four registers: one for control and status, one for channel select, and two for the result, a low byte and a high byte. The converter core itself lies outside the block. The block gives the core a channel index and a run signal. At the end of each conversion window it takes the 12-bit sample that the core presents.

A conversion starts when software writes one to the start bit. That bit reads back as one while the conversion runs, and the hardware clears it when the timed window ends. The window length is a parameter counted in clock cycles. Two things abandon a running conversion: clearing the enable bit, or asserting the low-power input. The channel is captured when a conversion starts, so rewriting the channel register mid-conversion only affects the next conversion. Completion loads the result register and sets a sticky flag. The flag drives the interrupt line while the interrupt-enable bit is set.

Top module: `conv_sequencer`

## Requirements
- R1: The enable bit (control register bit 0) gates all conversions. Writing it to zero during a conversion ends the conversion at that same edge: the busy bit drops, the result is not loaded and the flag is not set. The busy bit is never one while enable is zero.
- R2: An accepted start write sets the busy bit (control register read bit 1). Busy then reads one for exactly CONV_CYCLES cycles and returns to zero at the completion edge.
- R3: The channel driven on `core_chan` is captured when the conversion starts and stays unchanged until that conversion ends. A channel written during a conversion is used from the next start.
- R4: While `low_power` is high, a running conversion is abandoned at the next edge and start writes are refused.
- R5: The result register changes only at completion. During a conversion, and after an abandoned conversion, it still holds the previous sample.
- R6: Register 2 returns result bits 7:0. Reading register 2 (with `bus_re`) copies result bits 11:8 into a shadow. Register 3 returns that shadow in bits 3:0, so both bytes of a split read come from the same sample.
- R7: Completion sets the flag (control register bit 3). Writing one to bit 3 clears the flag. `irq` equals flag AND interrupt-enable (control register bit 2).
- R8: A start write while enable ends up zero is ignored. A start write during a running conversion neither restarts nor extends it.
- R9: A channel value of NUM_CH (11) or above drives channel 0 on `core_chan`. Register 1 still reads back the written 4-bit value.
- R10: Register layout. Address 0 is control: write bit 0 enable, bit 1 start, bit 2 interrupt enable, bit 3 flag clear. Reading address 0 gives {4'b0, flag, ie, busy, en}. Address 1 is the channel, address 2 the result low byte and address 3 the result high byte. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (side effect: high-byte shadow capture) |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| low_power | input | 1 | Any low-power mode is active |
| core_chan | output | 4 | Channel index for the converter core |
| core_run | output | 1 | A conversion is in progress |
| core_sample | input | 12 | Sample from the core, taken at completion |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The start write lands on edge k. Busy is visible at the first falling edge after k, and the bench samples it at every falling edge through the one after edge k+CONV_CYCLES-1. At the falling edge after k+CONV_CYCLES it expects busy clear, the flag set and the new result visible. Aborts, flag clears and refused starts act at the write edge, so the bench checks them at the next falling edge. The shadow-byte checks place a whole conversion between the low-byte read and the high-byte read. A channel sweep covers all sixteen select values, with a bench-side model of the sample.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CHAN   = 2'd1,
        REG_RES_LO = 2'd2,
        REG_RES_HI = 2'd3
    } reg_addr_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_GO   = 1;
    localparam int CTL_IE   = 2;
    localparam int CTL_FLAG = 3;
endpackage

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
    parameter int CONV_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = 1'b0;
        if (abort) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
                done       = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_req) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(CONV_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;

    // R2
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && !abort && tmr_q.cnt != '0) |=> tmr_q.busy);

    // R1
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !tmr_q.busy);

    // R2
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !tmr_q.busy);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && !abort && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));
endmodule

// File: rtl/conv_seq_chan.sv
module conv_seq_chan #(
    parameter int CH_W   = 4,
    parameter int NUM_CH = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_val,
    input  logic            latch,
    input  logic            busy,
    output logic [CH_W-1:0] sel,
    output logic [CH_W-1:0] conv_chan
);
    typedef struct packed {
        logic [CH_W-1:0] sel;
        logic [CH_W-1:0] conv;
    } chan_s;

    chan_s chan_d, chan_q;
    logic [CH_W-1:0] mapped;

    always_comb begin
        mapped = (int'(chan_q.sel) >= NUM_CH) ? '0 : chan_q.sel;
        chan_d = chan_q;
        if (wr_en) chan_d.sel  = wr_val;
        if (latch) chan_d.conv = mapped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign sel       = chan_q.sel;
    assign conv_chan = chan_q.conv;

    // R3
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !latch) |=> $stable(chan_q.conv));
endmodule

// File: rtl/conv_seq_result.sv
module conv_seq_result #(
    parameter int RES_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RES_W-1:0]  sample,
    input  logic              rd_lo,
    output logic [RES_W-1:0]  result,
    output logic [RES_W-DATA_W-1:0] hi_shadow
);
    localparam int HI_W = RES_W - DATA_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [HI_W-1:0]  hi;
    } res_s;

    res_s res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (rd_lo) res_d.hi  = res_q.res[RES_W-1:DATA_W];
        if (load)  res_d.res = sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result    = res_q.res;
    assign hi_shadow = res_q.hi;

    // R5
    res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(res_q.res));

    // R6
    shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (res_q.hi == $past(res_q.res[RES_W-1:DATA_W])));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 4000,
    parameter int NUM_CH      = 11,
    parameter int CH_W        = 4,
    parameter int RES_W       = 12,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              low_power,
    output logic [CH_W-1:0]   core_chan,
    output logic              core_run,
    input  logic [RES_W-1:0]  core_sample,
    output logic              irq
);
    localparam int HI_W = RES_W - DATA_W;

    typedef struct packed {
        logic en;
        logic ie;
        logic flag;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic wr_ctrl, wr_chan, rd_lo;
    logic abort, start_req, busy, done;
    logic [CH_W-1:0]  chan_sel;
    logic [RES_W-1:0] result;
    logic [HI_W-1:0]  hi_shadow;

    assign wr_ctrl = bus_we && (bus_addr == REG_CTRL);
    assign wr_chan = bus_we && (bus_addr == REG_CHAN);
    assign rd_lo   = bus_re && (bus_addr == REG_RES_LO);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.en = bus_wdata[CTL_EN];
            ctl_d.ie = bus_wdata[CTL_IE];
            if (bus_wdata[CTL_FLAG]) ctl_d.flag = 1'b0;
        end
        abort     = !ctl_d.en || low_power;
        start_req = wr_ctrl && bus_wdata[CTL_GO] && !abort;
        if (done) ctl_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    conv_seq_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .abort     (abort),
        .busy      (busy),
        .done      (done)
    );

    conv_seq_chan #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_chan),
        .wr_val    (bus_wdata[CH_W-1:0]),
        .latch     (start_req && !busy),
        .busy      (busy),
        .sel       (chan_sel),
        .conv_chan (core_chan)
    );

    conv_seq_result #(.RES_W(RES_W), .DATA_W(DATA_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .sample    (core_sample),
        .rd_lo     (rd_lo),
        .result    (result),
        .hi_shadow (hi_shadow)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTL_EN]   = ctl_q.en;
                bus_rdata[CTL_GO]   = busy;
                bus_rdata[CTL_IE]   = ctl_q.ie;
                bus_rdata[CTL_FLAG] = ctl_q.flag;
            end
            REG_CHAN:   bus_rdata = DATA_W'(chan_sel);
            REG_RES_LO: bus_rdata = result[DATA_W-1:0];
            REG_RES_HI: bus_rdata = DATA_W'(hi_shadow);
            default:    bus_rdata = '0;
        endcase
    end

    assign core_run = busy;
    assign irq      = ctl_q.flag && ctl_q.ie;

    // R7
    flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ctl_q.flag);

    // R1
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.en |-> !busy);

    // R4
    lp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && !busy) |=> !busy);
endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 8;
    localparam int NCH        = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        low_power = 1'b0;
    logic [3:0]  core_chan;
    logic        core_run;
    logic [11:0] core_sample;
    logic        irq;
    logic [7:0]  seed = 8'd0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    assign core_sample = {core_chan, seed};

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_sequencer #(.CONV_CYCLES(CONV)) u_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .low_power(low_power), .core_chan(core_chan), .core_run(core_run),
        .core_sample(core_sample), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; bus_addr = 2'd0;
    endtask

    // start conversion and walk the busy window (R2), ending after completion
    task automatic run_conv(input logic [7:0] ctl);
        logic [7:0] v;
        wr(2'd0, ctl);
        for (int i = 0; i < CONV; i++) begin
            peek(2'd0, v);
            check("R2 busy during window", v[1], 1);
            @(negedge clk);
        end
        peek(2'd0, v);
        check("R2 busy clear at end", v[1], 0);
        check("R7 flag set at end", v[3], 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] lo_prev;
        repeat (3) @(negedge clk);
        // R10 reset state
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], v);
            check("R10 reset register", v, 0);
        end
        check("R10 reset irq", irq, 0);
        check("R10 reset run", core_run, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 start with enable clear is ignored
        wr(2'd0, 8'h06);
        peek(2'd0, v);
        check("R8 start while disabled", v, 8'h04);
        check("R8 core_run while disabled", core_run, 0);

        // channel sweep: R9 mapping, R10 readback, R6 bytes, R7 irq
        for (int s = 0; s < 16; s++) begin
            int ec;
            ec = (s >= NCH) ? 0 : s;
            seed = 8'(s * 17 + 3);
            wr(2'd1, 8'(s));
            wr(2'd0, 8'h0D);
            peek(2'd0, v);
            check("R7 flag cleared by W1C", v[3], 0);
            check("R7 irq low after clear", irq, 0);
            wr(2'd0, 8'h07);
            check("R9 core_chan mapping", core_chan, ec);
            repeat (CONV) @(negedge clk);
            check("R7 irq with ie", irq, 1);
            peek(2'd1, v);
            check("R10 channel readback", v, s);
            rd(2'd2, v);
            check("R6 low byte", v, seed);
            rd(2'd3, v);
            check("R6 high byte", v, ec);
        end

        // R8 second start during conversion does not restart
        wr(2'd1, 8'd4); seed = 8'h5A;
        wr(2'd0, 8'h0D);
        wr(2'd0, 8'h07);
        @(negedge clk); @(negedge clk);
        wr(2'd0, 8'h07);
        repeat (3) @(negedge clk);
        peek(2'd0, v);
        check("R8 still busy before original end", v[1], 1);
        @(negedge clk);
        peek(2'd0, v);
        check("R8 completes at original end", v[1], 0);
        check("R8 flag at original end", v[3], 1);

        // R3 channel rewrite mid-conversion
        wr(2'd1, 8'd2); seed = 8'h31;
        wr(2'd0, 8'h0D);
        wr(2'd0, 8'h07);
        wr(2'd1, 8'd5);
        check("R3 core_chan held", core_chan, 2);
        repeat (CONV - 1) @(negedge clk);
        rd(2'd2, v);
        rd(2'd3, v);
        check("R3 result from old channel", v, 2);
        wr(2'd0, 8'h0D);
        wr(2'd0, 8'h07);
        check("R3 new channel next start", core_chan, 5);
        repeat (CONV) @(negedge clk);

        // R1 abort by clearing enable
        rd(2'd2, lo_prev);
        wr(2'd0, 8'h0D);
        seed = 8'hEE;
        wr(2'd0, 8'h07);
        @(negedge clk); @(negedge clk);
        wr(2'd0, 8'h04);
        peek(2'd0, v);
        check("R1 abort by enable clear", v, 8'h04);
        repeat (CONV + 2) @(negedge clk);
        peek(2'd0, v);
        check("R1 no flag after abort", v[3], 0);
        rd(2'd2, v);
        check("R5 result kept after abort", v, lo_prev);

        // R4 low-power abort and refusal
        wr(2'd0, 8'h05);
        wr(2'd0, 8'h07);
        @(negedge clk);
        low_power = 1'b1;
        @(negedge clk);
        check("R4 low-power abort", core_run, 0);
        wr(2'd0, 8'h07);
        check("R4 start refused in low power", core_run, 0);
        low_power = 1'b0;
        repeat (CONV + 1) @(negedge clk);
        peek(2'd0, v);
        check("R4 no flag after low-power abort", v[3], 0);
        rd(2'd2, v);
        check("R5 result kept after low-power abort", v, lo_prev);

        // R6 shadow: low read of A, conversion B, high read still A
        wr(2'd1, 8'd3); seed = 8'h11;
        run_conv(8'h07);
        rd(2'd2, v);
        check("R6 low byte A", v, 8'h11);
        wr(2'd1, 8'd7); seed = 8'h22;
        wr(2'd0, 8'h0D);
        // R5 result unchanged during conversion
        wr(2'd0, 8'h07);
        peek(2'd2, v);
        check("R5 old result while busy", v, 8'h11);
        repeat (CONV) @(negedge clk);
        rd(2'd3, v);
        check("R6 high from shadow of A", v, 3);
        rd(2'd2, v);
        check("R6 low byte B", v, 8'h22);
        rd(2'd3, v);
        check("R6 high byte B", v, 7);

        // R7 flag without ie gives no irq
        wr(2'd0, 8'h09);
        run_conv(8'h03);
        check("R7 irq masked by ie", irq, 0);
        wr(2'd0, 8'h05);
        check("R7 irq when ie set on pending flag", irq, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule